// File: doc/BRIEF.md
# Saturating INT8 Multiply-Accumulate Unit

This is a three-stage execution unit for a processor's coprocessor path. It runs four integer operations on signed 8-bit data. The first is a multiply-accumulate whose result is clamped to the signed 8-bit range. The second is a multiply-accumulate into a 32-bit accumulator that wraps. The third is a bare multiply. The fourth clamps a 32-bit value to the signed 8-bit range.

Each operation arrives with an opcode, two source register values and an accumulator value, all qualified by a valid strobe. Three clock edges later the unit returns a 32-bit result, a valid strobe and a saturation flag.

The unit holds no accumulator of its own. The running sum always travels in as an operand, so a speculative operation can be dropped without anything to undo. The decoder, the offload handshake and the register file sit outside this block.

Top module: `sat_mac8`

## Requirements
- R1: A synchronous active-high `rst` clears every valid bit in the pipeline. While `rst` is sampled high and on the following cycle, `out_valid` and `out_ovf` are low, and an operation in flight at reset never appears.
- R2: An operation sampled with `in_valid` high at a clock edge produces `out_valid` high exactly three edges later. One operation can be accepted per cycle, results leave in issue order, and idle cycles pass through as gaps.
- R3: The multiplier takes bits [7:0] of `in_rs1` and bits [7:0] of `in_rs2` as signed two's complement values. The upper bits of both sources do not affect multiply results.
- R4: Opcode 2'b00 computes `in_acc` (signed 32-bit) plus the 16-bit signed product. The sum is taken at full precision, clamped to -128..127 and sign-extended to 32 bits.
- R5: Opcode 2'b01 returns the 32-bit sum of `in_acc` and the sign-extended product, wrapping modulo 2^32. It never raises `out_ovf`.
- R6: Opcode 2'b10 returns the 16-bit signed product sign-extended to 32 bits. It never raises `out_ovf`.
- R7: Opcode 2'b11 clamps all 32 bits of `in_rs1`, read as a signed value, to -128..127 and sign-extends the result. `in_rs2` and `in_acc` are ignored.
- R8: A positive clamp yields 0x0000007F and a negative clamp yields 0xFFFFFF80. `out_ovf` is high exactly on valid results where a clamp changed the value. It is low on a value that sits exactly on a limit and low whenever `out_valid` is low.
- R9: A result depends only on the operands issued with it. Repeating an operation after other operations gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 2 | Operation code (00 clamped MAC, 01 wide MAC, 10 multiply, 11 clamp) |
| in_rs1 | input | 32 | First source register value |
| in_rs2 | input | 32 | Second source register value |
| in_acc | input | 32 | Accumulator operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Result, sign-extended where narrow |
| out_ovf | output | 1 | Saturation applied to this result |

## Verification
Retiring one result and accepting a new operation can fall in the same cycle. The pipeline is full whenever operations arrive back to back. The bench streams its whole vector table without gaps, so every retirement coincides with fresh issue. It judges each result and flag against the table entry three cycles older and confirms that no entry is skipped or repeated. A separate run with an idle cycle between two operations checks that the gap comes out as a gap, and a reset with an operation in flight checks that nothing emerges.

// File: rtl/sat_mac8.sv
module sat_mac8 #(
  parameter int XLEN = 32,
  parameter int OPW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  input  logic [XLEN-1:0] in_acc,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_ovf
);
  localparam int PW = 2 * OPW;
  localparam int SW = XLEN + 2;
  localparam logic [1:0] OP_MACS = 2'b00;
  localparam logic [1:0] OP_MACW = 2'b01;
  localparam logic [1:0] OP_MUL  = 2'b10;
  localparam logic [1:0] OP_CLIP = 2'b11;
  localparam logic signed [SW-1:0] LIM_HI = SW'((1 <<< (OPW - 1)) - 1);
  localparam logic signed [SW-1:0] LIM_LO = -SW'(1 <<< (OPW - 1));

  logic                   s1_v, s2_v;
  logic [1:0]             s1_op, s2_op;
  logic signed [OPW-1:0]  s1_a, s1_b;
  logic [XLEN-1:0]        s1_acc, s1_rs1, s2_acc, s2_rs1;
  logic signed [PW-1:0]   s2_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= in_valid;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_op   <= in_op;
    s1_a    <= in_rs1[OPW-1:0];
    s1_b    <= in_rs2[OPW-1:0];
    s1_acc  <= in_acc;
    s1_rs1  <= in_rs1;
    s2_op   <= s1_op;
    s2_prod <= s1_a * s1_b;
    s2_acc  <= s1_acc;
    s2_rs1  <= s1_rs1;
  end

  wire [XLEN-1:0]        prod_x = {{(XLEN-PW){s2_prod[PW-1]}}, s2_prod};
  wire signed [SW-1:0]   sum_x  = $signed({{2{s2_acc[XLEN-1]}}, s2_acc})
                                + $signed({{2{prod_x[XLEN-1]}}, prod_x});
  wire signed [SW-1:0]   rs1_x  = $signed({{2{s2_rs1[XLEN-1]}}, s2_rs1});
  wire signed [SW-1:0]   sat_in = (s2_op == OP_CLIP) ? rs1_x : sum_x;
  wire                   too_hi = sat_in > LIM_HI;
  wire                   too_lo = sat_in < LIM_LO;
  wire signed [SW-1:0]   sat_v  = too_hi ? LIM_HI : (too_lo ? LIM_LO : sat_in);
  wire [XLEN-1:0]        wrap_v = s2_acc + prod_x;

  logic [XLEN-1:0] res_n;
  always_comb begin
    case (s2_op)
      OP_MACW: res_n = wrap_v;
      OP_MUL:  res_n = prod_x;
      default: res_n = sat_v[XLEN-1:0];
    endcase
  end

  wire ovf_n = s2_v && (s2_op == OP_MACS || s2_op == OP_CLIP) && (too_hi || too_lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= s2_v;
      out_ovf   <= ovf_n;
    end
    out_result <= res_n;
  end
endmodule

// File: rtl/sat_mac8_chk.sv
module sat_mac8_chk #(
  parameter int XLEN = 32,
  parameter int OPW  = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [1:0]      in_op,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic            out_ovf
);
  localparam int PW = 2 * OPW;
  localparam logic [XLEN-1:0] V_HI = XLEN'((1 << (OPW - 1)) - 1);
  localparam logic [XLEN-1:0] V_LO = ~XLEN'((1 << (OPW - 1)) - 1);

  logic [2:0] vq;
  logic [1:0] oq0, oq1, oq2;
  always_ff @(posedge clk) begin
    if (rst) vq <= '0;
    else     vq <= {vq[1:0], in_valid};
    oq0 <= in_op;
    oq1 <= oq0;
    oq2 <= oq1;
  end

  wire [XLEN-OPW:0] hi_narrow = out_result[XLEN-1:OPW-1];
  wire [XLEN-PW:0]  hi_prod   = out_result[XLEN-1:PW-1];

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!out_valid && !out_ovf));
  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst) out_valid == vq[2]);
  p_narrow_sext_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (oq2 == 2'b00 || oq2 == 2'b11)) |-> ((&hi_narrow) || !(|hi_narrow)));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (oq2 == 2'b01 || oq2 == 2'b10)) |-> !out_ovf);
  p_prod_sext_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && oq2 == 2'b10) |-> ((&hi_prod) || !(|hi_prod)));
  p_sat_value_r8: assert property (@(posedge clk) disable iff (rst)
    out_ovf |-> (out_result == V_HI || out_result == V_LO));
  p_idle_no_ovf_r8: assert property (@(posedge clk) disable iff (rst) !out_valid |-> !out_ovf);
endmodule

bind sat_mac8 sat_mac8_chk #(.XLEN(XLEN), .OPW(OPW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
  .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf));

// File: tb/sim_sat_mac8.sv
module sim_sat_mac8;
  localparam int CLK_PERIOD = 10;
  localparam int N = 17;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [1:0] in_op = '0;
  logic [31:0] in_rs1 = '0, in_rs2 = '0, in_acc = '0;
  logic out_valid, out_ovf;
  logic [31:0] out_result;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sat_mac8 u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_acc(in_acc),
    .out_valid(out_valid), .out_result(out_result), .out_ovf(out_ovf));

  // {op, rs1, rs2, acc, expected result, expected overflow}
  localparam logic [130:0] VEC [N] = '{
    {2'd0, 32'h00000003, 32'h00000004, 32'h00000005, 32'h00000011, 1'b0},
    {2'd0, 32'h0000007F, 32'h0000007F, 32'h00000000, 32'h0000007F, 1'b1},
    {2'd0, 32'h00000080, 32'h0000007F, 32'h00000000, 32'hFFFFFF80, 1'b1},
    {2'd0, 32'hFFFFFF02, 32'hAB0000FD, 32'h00000004, 32'hFFFFFFFE, 1'b0}, // R3 upper bits ignored
    {2'd0, 32'h00000001, 32'h00000001, 32'h0000007E, 32'h0000007F, 1'b0},
    {2'd0, 32'h000000FF, 32'h00000001, 32'hFFFFFF81, 32'hFFFFFF80, 1'b0},
    {2'd0, 32'h00000000, 32'h00000000, 32'h80000000, 32'hFFFFFF80, 1'b1},
    {2'd1, 32'h00000080, 32'h00000080, 32'h7FFFFFFF, 32'h80003FFF, 1'b0},
    {2'd1, 32'h00000010, 32'h000000F0, 32'h00000064, 32'hFFFFFF64, 1'b0},
    {2'd2, 32'h00000080, 32'h00000080, 32'h12345678, 32'h00004000, 1'b0},
    {2'd2, 32'h00000080, 32'h0000007F, 32'h00000000, 32'hFFFFC080, 1'b0},
    {2'd3, 32'h00000200, 32'h00000055, 32'h00000077, 32'h0000007F, 1'b1},
    {2'd3, 32'hFFFFFF7F, 32'h00000000, 32'h00000000, 32'hFFFFFF80, 1'b1},
    {2'd3, 32'hFFFFFF80, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFF80, 1'b0},
    {2'd3, 32'h0000007F, 32'h00000000, 32'h00000000, 32'h0000007F, 1'b0},
    {2'd3, 32'h000000FF, 32'h00000000, 32'h00000000, 32'h0000007F, 1'b1},
    {2'd0, 32'h00000003, 32'h00000004, 32'h00000005, 32'h00000011, 1'b0}  // R9 repeat of first
  };

  function automatic string req_of(input logic [1:0] op);
    case (op)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] c);
    in_valid = v; in_op = op; in_rs1 = a; in_rs2 = b; in_acc = c;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int rx;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1 ovf after reset", {31'd0, out_ovf}, 32'd0);
    rst = 1'b0;

    // back-to-back stream: retirement and issue share every cycle
    rx = 0;
    for (int i = 0; i < N + 4; i++) begin
      @(negedge clk);
      if (i >= 3 && i < N + 3)
        check("R2 valid in stream", {31'd0, out_valid}, 32'd1);
      if (out_valid && rx < N) begin
        check(req_of(VEC[rx][130:129]), out_result, VEC[rx][32:1]);
        check("R8 overflow flag", {31'd0, out_ovf}, {31'd0, VEC[rx][0]});
        rx++;
      end
      if (i < N) drive(1'b1, VEC[i][130:129], VEC[i][128:97], VEC[i][96:65], VEC[i][64:33]);
      else       drive(1'b0, 2'd0, 32'd0, 32'd0, 32'd0);
    end
    check("R2 result count", rx, N);

    // exact latency of a single op: R2
    @(negedge clk);
    drive(1'b1, 2'd2, 32'd5, 32'd6, 32'd0);
    @(negedge clk); drive(1'b0, 2'd0, 32'd0, 32'd0, 32'd0);
    check("R2 not yet valid 1", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R2 not yet valid 2", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R2 valid at 3", {31'd0, out_valid}, 32'd1);
    check("R6 latency result", out_result, 32'd30);
    @(negedge clk);
    check("R2 single pulse", {31'd0, out_valid}, 32'd0);

    // bubble preserved and order kept: R2
    drive(1'b1, 2'd2, 32'd2, 32'd3, 32'd0);
    @(negedge clk); drive(1'b0, 2'd0, 32'd0, 32'd0, 32'd0);
    @(negedge clk); drive(1'b1, 2'd2, 32'd7, 32'hFF, 32'd0);
    @(negedge clk); drive(1'b0, 2'd0, 32'd0, 32'd0, 32'd0);
    check("R2 first of pair valid", {31'd0, out_valid}, 32'd1);
    check("R2 first of pair", out_result, 32'd6);
    @(negedge clk);
    check("R2 bubble", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    check("R2 second of pair valid", {31'd0, out_valid}, 32'd1);
    check("R2 second of pair", out_result, 32'hFFFFFFF9);

    // reset with an op in flight: R1
    @(negedge clk);
    drive(1'b1, 2'd3, 32'h00000400, 32'd0, 32'd0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; drive(1'b0, 2'd0, 32'd0, 32'd0, 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 flushed valid", {31'd0, out_valid}, 32'd0);
      check("R1 flushed ovf", {31'd0, out_ovf}, 32'd0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule